// File: doc/BRIEF.md
# Lane Override Sequencer

This block forces receive-mode and transmit-attenuation settings onto one lane of a multi-lane serial transceiver. The transceiver's lane registers are reached only through a separate register access engine. The block takes a one-cycle command together with a lane number, a DPLL mode and a 4-bit attenuation code. It then runs a fixed chain of register reads and read-modify-writes through the engine, one transaction at a time. First it waits for the lane to leave half-rate operation. Next it takes ownership of the receive settings, loads the DPLL mode and pulses the DPLL reset. It then idles for a settle time, and last it takes ownership of the transmit settings and loads the attenuation. A second command hands receive control back to the lane by clearing the receive ownership bit.

Toward the engine the block has a valid/ready request channel and a valid/ready response channel. The block holds a request, with address, direction and data unchanged, until the engine accepts it. Only one transaction is ever outstanding. `rsp_ready` is high only while the block waits for the answer to the accepted request. Every request, read or write, must be answered by exactly one response beat, and the block issues nothing new until that beat arrives. The engine may stall either channel for any number of cycles.

Top module: `lane_override_seq`

## Requirements
- R1: After reset `busy`, `done`, `req_valid` and `rsp_ready` are all low, and they stay low until a command arrives.
- R2: Each register address is a fixed offset plus lane × 0x100. The offsets are 0x2002 for receive status, 0x2005 for receive override, 0x2001 for transmit status and 0x2004 for transmit override. Writes only ever target the two override registers.
- R3: A start command first reads receive status repeatedly while bit 0 (half-rate) of the returned word is 1. It stops after the first read that returns bit 0 clear, or after MAX_POLL reads (default 1000), whichever comes first.
- R4: After polling, receive status is read once more into a working word W. The block then writes W to the receive override register five times, updating W before each write in this order: clear bit 14; set bit 14; replace bits 10:8 with the DPLL mode; set bit 11; clear bit 11.
- R5: After the fifth receive write is answered, the block issues no request for at least SETTLE_CYCLES cycles.
- R6: When bit 3 of the attenuation code is 1, the transmit phase is skipped, and `done` follows the settle time directly.
- R7: Otherwise transmit status is read into W. W is then written to the transmit override register three times, updated before each write in this order: clear bit 15; set bit 15; OR the attenuation bits 2:0 into bits 12:10.
- R8: A clear command reads receive status for its lane, writes that word with bit 14 cleared to the receive override register, and then finishes.
- R9: A request stays valid with stable address, direction and data until accepted. Only one transaction is outstanding at a time, and each request receives exactly one response.
- R10: `busy` is high from the cycle after an accepted command until the sequence ends. `done` is a one-cycle pulse in the first idle cycle after the last transaction or the settle time.
- R11: If start and clear arrive in the same idle cycle, start is taken and clear is dropped. Commands that arrive while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovr_start | input | 1 | Pulse: run the full override sequence |
| ovr_clear | input | 1 | Pulse: release the receive override |
| lane_sel | input | LANE_W | Target lane, captured with the command |
| dpll_mode | input | 3 | DPLL mode for bits 10:8 (3 is the usual value) |
| tx_atten | input | 4 | Attenuation; bit 3 set skips the transmit phase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Block waits for a response |
| rsp_rdata | input | DATA_W | Read data (ignored for writes) |

## Verification
Two things can meet in one idle cycle: a start and a clear command. The bench drives both high on the same clock and then compares the full transaction log against the start sequence alone. It also waits past `done` to confirm that no stray clear read or write follows. A second case injects a clear on another lane while the start sequence is mid-flight. The log must then still match the start sequence exactly, with every address on the original lane.

// File: rtl/lovr_pkg.sv
package lovr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_RX_RD,
    ST_RX_CLR,
    ST_RX_SET,
    ST_RX_MODE,
    ST_RX_RSTH,
    ST_RX_RSTL,
    ST_SETTLE,
    ST_TX_RD,
    ST_TX_CLR,
    ST_TX_SET,
    ST_TX_ATT,
    ST_DIS_RD,
    ST_DIS_WR
  } step_e;

  typedef enum logic [1:0] {
    REG_TX_STS,
    REG_RX_STS,
    REG_TX_OVR,
    REG_RX_OVR
  } reg_sel_e;

  localparam logic [15:0] OFS_TX_STS = 16'h2001;
  localparam logic [15:0] OFS_RX_STS = 16'h2002;
  localparam logic [15:0] OFS_TX_OVR = 16'h2004;
  localparam logic [15:0] OFS_RX_OVR = 16'h2005;

  localparam int BIT_HALF   = 0;
  localparam int BIT_RX_OWN = 14;
  localparam int BIT_TX_OWN = 15;
  localparam int BIT_DRST   = 11;
  localparam int MODE_LSB   = 8;
  localparam int ATT_LSB    = 10;

endpackage

// File: rtl/lovr_addr_map.sv
module lovr_addr_map
  import lovr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LANE_W      = 2,
  parameter int LANE_STRIDE = 'h100
) (
  input  reg_sel_e            sel,
  input  logic [LANE_W-1:0]   lane,
  output logic [ADDR_W-1:0]   addr
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] lane_off;

  always_comb begin
    case (sel)
      REG_TX_STS: base = ADDR_W'(OFS_TX_STS);
      REG_RX_STS: base = ADDR_W'(OFS_RX_STS);
      REG_TX_OVR: base = ADDR_W'(OFS_TX_OVR);
      default:    base = ADDR_W'(OFS_RX_OVR);
    endcase
  end

  assign lane_off = ADDR_W'(lane) * ADDR_W'(LANE_STRIDE);
  assign addr     = base + lane_off;

endmodule

// File: rtl/lovr_counter.sv
module lovr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + W'(1);
    end
  end

endmodule

// File: rtl/lovr_req_port.sv
module lovr_req_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_write,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              ack,
  output logic [DATA_W-1:0] ack_data
);

  logic waiting;

  assign rsp_ready = waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      waiting   <= 1'b0;
      ack       <= 1'b0;
      ack_data  <= '0;
    end else begin
      ack <= 1'b0;
      if (issue) begin
        req_valid <= 1'b1;
        req_write <= issue_write;
        req_addr  <= issue_addr;
        req_wdata <= issue_wdata;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        waiting   <= 1'b1;
      end
      if (waiting && rsp_valid) begin
        waiting  <= 1'b0;
        ack      <= 1'b1;
        ack_data <= rsp_rdata;
      end
    end
  end

endmodule

// File: rtl/lovr_step_ctrl.sv
module lovr_step_ctrl
  import lovr_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int LANE_W        = 2,
  parameter int MAX_POLL      = 1000,
  parameter int SETTLE_CYCLES = 1500,
  parameter int PW            = 10,
  parameter int SW            = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_clear,
  input  logic [LANE_W-1:0] lane_in,
  input  logic [2:0]        mode_in,
  input  logic [3:0]        att_in,
  input  logic              ack,
  input  logic [DATA_W-1:0] ack_data,
  input  logic [PW-1:0]     poll_cnt,
  input  logic [SW-1:0]     settle_cnt,
  output logic              poll_clr,
  output logic              poll_inc,
  output logic              settle_clr,
  output logic              settle_inc,
  output logic              issue,
  output logic              issue_write,
  output reg_sel_e          issue_sel,
  output logic [DATA_W-1:0] issue_wdata,
  output logic [LANE_W-1:0] lane_q,
  output logic              busy,
  output logic              done
);

  localparam logic [PW-1:0] POLL_LAST   = PW'(MAX_POLL - 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);
  localparam logic [DATA_W-1:0] M_RX_OWN = DATA_W'(1) << BIT_RX_OWN;
  localparam logic [DATA_W-1:0] M_TX_OWN = DATA_W'(1) << BIT_TX_OWN;
  localparam logic [DATA_W-1:0] M_DRST   = DATA_W'(1) << BIT_DRST;
  localparam logic [DATA_W-1:0] M_MODE   = DATA_W'(7) << MODE_LSB;

  step_e             state;
  logic              pending;
  logic              req_state;
  logic [DATA_W-1:0] work;
  logic [2:0]        mode_q;
  logic [3:0]        att_q;

  always_comb begin
    req_state   = 1'b1;
    issue_sel   = REG_RX_STS;
    issue_write = 1'b0;
    issue_wdata = work;
    case (state)
      ST_POLL, ST_RX_RD, ST_DIS_RD: issue_sel = REG_RX_STS;
      ST_RX_CLR, ST_DIS_WR: begin
        issue_sel   = REG_RX_OVR;
        issue_write = 1'b1;
        issue_wdata = work & ~M_RX_OWN;
      end
      ST_RX_SET: begin
        issue_sel   = REG_RX_OVR;
        issue_write = 1'b1;
        issue_wdata = work | M_RX_OWN;
      end
      ST_RX_MODE: begin
        issue_sel   = REG_RX_OVR;
        issue_write = 1'b1;
        issue_wdata = (work & ~M_MODE) | (DATA_W'(mode_q) << MODE_LSB);
      end
      ST_RX_RSTH: begin
        issue_sel   = REG_RX_OVR;
        issue_write = 1'b1;
        issue_wdata = work | M_DRST;
      end
      ST_RX_RSTL: begin
        issue_sel   = REG_RX_OVR;
        issue_write = 1'b1;
        issue_wdata = work & ~M_DRST;
      end
      ST_TX_RD: issue_sel = REG_TX_STS;
      ST_TX_CLR: begin
        issue_sel   = REG_TX_OVR;
        issue_write = 1'b1;
        issue_wdata = work & ~M_TX_OWN;
      end
      ST_TX_SET: begin
        issue_sel   = REG_TX_OVR;
        issue_write = 1'b1;
        issue_wdata = work | M_TX_OWN;
      end
      ST_TX_ATT: begin
        issue_sel   = REG_TX_OVR;
        issue_write = 1'b1;
        issue_wdata = work | (DATA_W'(att_q[2:0]) << ATT_LSB);
      end
      default: req_state = 1'b0;
    endcase
  end

  assign issue      = req_state && !pending;
  assign poll_clr   = (state == ST_IDLE);
  assign poll_inc   = ack && (state == ST_POLL);
  assign settle_clr = (state != ST_SETTLE);
  assign settle_inc = (state == ST_SETTLE);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      work    <= '0;
      mode_q  <= '0;
      att_q   <= '0;
      lane_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (issue) pending <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            lane_q <= lane_in;
            mode_q <= mode_in;
            att_q  <= att_in;
            state  <= ST_POLL;
          end else if (cmd_clear) begin
            lane_q <= lane_in;
            state  <= ST_DIS_RD;
          end
        end
        ST_SETTLE: begin
          if (settle_cnt == SETTLE_LAST) begin
            if (att_q[3]) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_TX_RD;
            end
          end
        end
        default: begin
          if (ack) begin
            pending <= 1'b0;
            work    <= issue_write ? issue_wdata : ack_data;
            case (state)
              ST_POLL:
                if (!(ack_data[BIT_HALF] && (poll_cnt != POLL_LAST)))
                  state <= ST_RX_RD;
              ST_RX_RD:   state <= ST_RX_CLR;
              ST_RX_CLR:  state <= ST_RX_SET;
              ST_RX_SET:  state <= ST_RX_MODE;
              ST_RX_MODE: state <= ST_RX_RSTH;
              ST_RX_RSTH: state <= ST_RX_RSTL;
              ST_RX_RSTL: state <= ST_SETTLE;
              ST_TX_RD:   state <= ST_TX_CLR;
              ST_TX_CLR:  state <= ST_TX_SET;
              ST_TX_SET:  state <= ST_TX_ATT;
              ST_DIS_RD:  state <= ST_DIS_WR;
              default: begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/lane_override_seq.sv
module lane_override_seq
  import lovr_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int LANE_STRIDE   = 'h100,
  parameter int MAX_POLL      = 1000,
  parameter int SETTLE_CYCLES = 1500,
  localparam int LANE_W       = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovr_start,
  input  logic              ovr_clear,
  input  logic [LANE_W-1:0] lane_sel,
  input  logic [2:0]        dpll_mode,
  input  logic [3:0]        tx_atten,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_rdata
);

  localparam int PW = $clog2(MAX_POLL + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  logic              poll_clr, poll_inc, settle_clr, settle_inc;
  logic [PW-1:0]     poll_cnt;
  logic [SW-1:0]     settle_cnt;
  logic              issue, issue_write, ack;
  reg_sel_e          issue_sel;
  logic [DATA_W-1:0] issue_wdata, ack_data;
  logic [LANE_W-1:0] lane_q;
  logic [ADDR_W-1:0] issue_addr;

  lovr_step_ctrl #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .MAX_POLL(MAX_POLL),
    .SETTLE_CYCLES(SETTLE_CYCLES), .PW(PW), .SW(SW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(ovr_start), .cmd_clear(ovr_clear),
    .lane_in(lane_sel), .mode_in(dpll_mode), .att_in(tx_atten),
    .ack(ack), .ack_data(ack_data),
    .poll_cnt(poll_cnt), .settle_cnt(settle_cnt),
    .poll_clr(poll_clr), .poll_inc(poll_inc),
    .settle_clr(settle_clr), .settle_inc(settle_inc),
    .issue(issue), .issue_write(issue_write), .issue_sel(issue_sel),
    .issue_wdata(issue_wdata), .lane_q(lane_q),
    .busy(busy), .done(done)
  );

  lovr_counter #(.W(PW)) u_poll_cnt (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .count(poll_cnt)
  );

  lovr_counter #(.W(SW)) u_settle_cnt (
    .clk(clk), .rst_n(rst_n), .clr(settle_clr), .inc(settle_inc), .count(settle_cnt)
  );

  lovr_addr_map #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANE_STRIDE(LANE_STRIDE)
  ) u_map (
    .sel(issue_sel), .lane(lane_q), .addr(issue_addr)
  );

  lovr_req_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .issue(issue), .issue_write(issue_write),
    .issue_addr(issue_addr), .issue_wdata(issue_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ack(ack), .ack_data(ack_data)
  );

endmodule

// File: rtl/lovr_chk.sv
module lovr_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ovr_start,
  input logic              ovr_clear,
  input logic              busy,
  input logic              done,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_ready
);

  // R1: nothing moves on the engine channels while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !rsp_ready));

  // R2: writes land only on the override registers (low byte 0x04 / 0x05)
  p_write_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_addr[7:0] == 8'h04 || req_addr[7:0] == 8'h05));

  // R9: request held stable until accepted
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));

  // R9: a single outstanding transaction
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: leaving the busy state coincides with done
  p_done_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10: an idle command makes the block busy
  p_cmd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (ovr_start || ovr_clear)) |=> busy);

endmodule

bind lane_override_seq lovr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_start(ovr_start), .ovr_clear(ovr_clear),
  .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_ready(rsp_ready)
);

// File: tb/sim_lane_override_seq.sv
`timescale 1ns/1ps
module sim_lane_override_seq;

  localparam int MAXP   = 1000;
  localparam int SETTLE = 200;
  localparam int LOGN   = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovr_start = 1'b0, ovr_clear = 1'b0;
  logic [1:0] lane_sel = '0;
  logic [2:0] dpll_mode = '0;
  logic [3:0] tx_atten = '0;
  logic busy, done, req_valid, req_write, rsp_ready;
  logic [15:0] req_addr, req_wdata;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [15:0] rsp_rdata = '0;

  always #4 clk = ~clk;

  lane_override_seq #(.MAX_POLL(MAXP), .SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .ovr_start(ovr_start), .ovr_clear(ovr_clear),
    .lane_sel(lane_sel), .dpll_mode(dpll_mode), .tx_atten(tx_atten),
    .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  int tests = 0, fails = 0;
  bit fin = 0;
  int cyc = 0;

  // engine model state
  int m_k = 0, rd_idx = 0;
  logic [15:0] m_rx = '0, m_tx = '0;
  logic [1:0] m_lane = '0;
  logic [15:0] stash = '0;
  bit req_hs_pend = 0, rsp_hs_pend = 0, have_rsp = 0;
  int rsp_dly = 0;
  int log_n = 0, rsp_cnt = 0, done_cnt = 0, done_cyc = 0;
  bit done_prev = 0, done_wide = 0;
  logic [15:0] log_addr [LOGN];
  logic        log_we   [LOGN];
  logic [15:0] log_wd   [LOGN];
  int          log_cyc  [LOGN];

  // expected log
  int exp_n = 0;
  logic [15:0] exp_addr [LOGN];
  logic        exp_we   [LOGN];
  logic [15:0] exp_wd   [LOGN];
  string       exp_tag  [LOGN];
  int          settle_idx = -1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rsp_hs_pend) begin rsp_hs_pend = 0; rsp_valid = 1'b0; rsp_cnt++; end
      if (req_hs_pend) begin req_hs_pend = 0; have_rsp = 1; rsp_dly = $urandom % 3; end
      if (have_rsp && !rsp_valid) begin
        if (rsp_dly == 0) begin rsp_valid = 1'b1; rsp_rdata = stash; have_rsp = 0; end
        else rsp_dly--;
      end
      req_ready = ($urandom % 4) != 0;
      if (req_valid && req_ready) begin
        if (log_n < LOGN) begin
          log_addr[log_n] = req_addr; log_we[log_n] = req_write;
          log_wd[log_n] = req_wdata; log_cyc[log_n] = cyc;
        end
        log_n++;
        if (req_write) stash = 16'h0;
        else if (req_addr == 16'h2002 + 16'(m_lane) * 16'h100) begin
          stash = (m_rx & ~16'h1) | ((rd_idx < m_k) ? 16'h1 : 16'h0);
          rd_idx++;
        end else if (req_addr == 16'h2001 + 16'(m_lane) * 16'h100) stash = m_tx;
        else stash = 16'hDEAD;
        req_hs_pend = 1;
      end
      if (rsp_valid && rsp_ready) rsp_hs_pend = 1;
      if (done) begin
        done_cnt++; done_cyc = cyc;
        if (done_prev) done_wide = 1;
      end
      done_prev = done;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(negedge clk) begin
    if (cyc > 190000 && !fin) begin
      fin = 1; tests++; fails++;
      $display("FAIL watchdog: act cycles=%0d exp below 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic w, input logic [15:0] d, input string t);
    exp_addr[exp_n] = a; exp_we[exp_n] = w; exp_wd[exp_n] = d; exp_tag[exp_n] = t;
    exp_n++;
  endtask

  function automatic logic [15:0] rx_val(input int i);
    return (m_rx & ~16'h1) | ((i < m_k) ? 16'h1 : 16'h0);
  endfunction

  // builds the expected transaction list from the requirements
  task automatic build(input bit is_start, input int ln, input int md, input int at);
    logic [15:0] lo, t;
    int p;
    lo = 16'(ln) * 16'h100;
    exp_n = 0; settle_idx = -1;
    if (!is_start) begin
      push(16'h2002 + lo, 1'b0, 16'h0, "R8");
      push(16'h2005 + lo, 1'b1, rx_val(0) & ~16'h4000, "R8");
      return;
    end
    p = 0;
    for (int i = 0; i < MAXP; i++) begin           // R3 poll
      push(16'h2002 + lo, 1'b0, 16'h0, "R3");
      p++;
      if (!rx_val(i)[0]) break;
    end
    push(16'h2002 + lo, 1'b0, 16'h0, "R4");
    t = rx_val(p) & ~16'h4000;             push(16'h2005 + lo, 1'b1, t, "R4");
    t = t | 16'h4000;                      push(16'h2005 + lo, 1'b1, t, "R4");
    t = (t & ~16'h0700) | (16'(md) << 8);  push(16'h2005 + lo, 1'b1, t, "R4");
    t = t | 16'h0800;                      push(16'h2005 + lo, 1'b1, t, "R4");
    t = t & ~16'h0800;                     push(16'h2005 + lo, 1'b1, t, "R4");
    settle_idx = exp_n - 1;
    if (at[3]) return;                     // R6 skip
    push(16'h2001 + lo, 1'b0, 16'h0, "R7");
    t = m_tx & ~16'h8000;                  push(16'h2004 + lo, 1'b1, t, "R7");
    t = t | 16'h8000;                      push(16'h2004 + lo, 1'b1, t, "R7");
    t = t | (16'(at & 7) << 10);           push(16'h2004 + lo, 1'b1, t, "R7");
  endtask

  task automatic run_cmd(input bit is_start, input bit both, input bit busy_clear,
                         input int ln, input int md, input int at, input int k,
                         input string tag);
    int d0, t;
    m_k = is_start ? k : 0; rd_idx = 0;
    m_rx = 16'($urandom); m_tx = 16'($urandom); m_lane = 2'(ln);
    build(is_start, ln, md, at);
    @(negedge clk);
    log_n = 0; rsp_cnt = 0; done_wide = 0; d0 = done_cnt;
    lane_sel = 2'(ln); dpll_mode = 3'(md); tx_atten = 4'(at);
    ovr_start = is_start; ovr_clear = !is_start || both;
    @(negedge clk);
    ovr_start = 1'b0; ovr_clear = 1'b0;
    lane_sel = 2'($urandom); dpll_mode = 3'($urandom); tx_atten = 4'($urandom);
    chk(busy === 1'b1, "R10", "busy after command", 32'(busy), 1);
    if (busy_clear) begin
      repeat (10) @(negedge clk);
      lane_sel = 2'(ln + 1); ovr_clear = 1'b1;   // R11: ignored while busy
      @(negedge clk);
      ovr_clear = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    chk(log_n == exp_n, tag, "transaction count", 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_addr[i] == exp_addr[i], "R2", "address", 32'(log_addr[i]), 32'(exp_addr[i]));
      chk(log_we[i] == exp_we[i] && (!exp_we[i] || log_wd[i] == exp_wd[i]),
          exp_tag[i], "write/data", {15'h0, log_we[i], log_wd[i]},
          {15'h0, exp_we[i], exp_wd[i]});
    end
    chk(rsp_cnt == log_n, "R9", "responses per request", 32'(rsp_cnt), 32'(log_n));
    chk(done_cnt == d0 + 1 && !done_wide, "R10", "single done pulse",
        32'(done_cnt - d0), 1);
    if (settle_idx >= 0 && settle_idx < log_n) begin
      if (settle_idx + 1 < log_n)
        chk(log_cyc[settle_idx + 1] - log_cyc[settle_idx] >= SETTLE, "R5", "settle gap",
            32'(log_cyc[settle_idx + 1] - log_cyc[settle_idx]), SETTLE);
      else
        chk(done_cyc - log_cyc[settle_idx] >= SETTLE, "R6", "settle before done",
            32'(done_cyc - log_cyc[settle_idx]), SETTLE);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !req_valid && !rsp_ready, "R1", "reset outputs",
        {28'h0, busy, done, req_valid, rsp_ready}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !req_valid, "R1", "idle after reset", {30'h0, busy, req_valid}, 0);

    run_cmd(1, 0, 0, 0, 3, 2,    0,    "R4");   // plain override, no half-rate
    run_cmd(1, 0, 0, 3, 5, 5,    3,    "R3");   // a few polls, lane 3
    run_cmd(1, 0, 0, 1, 3, 4'hA, 1,    "R6");   // attenuation bit 3: skip tx
    run_cmd(0, 0, 0, 2, 0, 0,    0,    "R8");   // release command
    run_cmd(1, 1, 0, 1, 2, 7,    2,    "R11");  // start and clear together
    run_cmd(1, 0, 1, 0, 3, 3,    4,    "R11");  // clear while busy
    run_cmd(1, 0, 0, 2, 6, 1,    1200, "R3");   // poll limit hit
    run_cmd(1, 0, 0, 3, 3, 6,    999,  "R3");   // clears on the last allowed read
    for (int n = 0; n < 8; n++) begin
      int kind;
      kind = $urandom % 5;
      run_cmd(kind != 0, 0, 0, $urandom % 4, $urandom % 8, $urandom % 16,
              $urandom % 6, (kind != 0) ? "R7" : "R8");
    end

    fin = 1;
    summary();
    $finish;
  end

endmodule